// File: doc/BRIEF.md
# Scaler Step and Phase Calculator

This block derives the two constants a digital differential analyser needs to resample one image axis: the source advance per destination pixel (the step) and the starting sub-pixel offset (the phase). Both sizes arrive as unsigned 20.12 fixed-point values, so fractional source extents are accepted. The step is the source span divided by the destination span. The source span is the source size less one whole unit. The destination span is the destination size less one unit, floored at one unit. The quotient is then clamped to a ceiling that depends on the scaling axis and, for the horizontal axis, on the pixel width in bytes.

A caller presents the operands and pulses `start` while `busy` is low. A restoring divider produces one quotient bit per clock. The step, phase and warning outputs update together in the cycle where `done` pulses, and they hold their values until the next result. The reset is asynchronous and active low; its release must already be synchronised to `clk` by the surrounding logic.

Top module: `scl_dda_step`

## Requirements
- R1: The dividend is `in_size` minus 1.0 (0x1000). When `in_size` is below 1.0 the dividend is zero, so `step` is 0.
- R2: The divisor is `out_size` minus 1.0 when `out_size` is at least 2.0 (0x2000), and exactly 1.0 otherwise, including an output size of zero.
- R3: Before clamping, `step` equals floor(dividend * 4096 / divisor), with all values in unsigned 20.12 format.
- R4: When `vert` is 1, `step` never exceeds 15.0 (0xF000), and a larger quotient yields exactly 0xF000.
- R5: When `vert` is 0, the ceiling is 8.0 (0x8000) for `bpp` code 2 and 4.0 (0x4000) for `bpp` code 4.
- R6: When `vert` is 0 and `bpp` is neither 2 nor 4, the ceiling is 4.0 and `bpp_warn` is 1 with that result. Otherwise `bpp_warn` is 0, and it is always 0 when `vert` is 1.
- R7: `phase` equals the low 12 bits (the fraction field) of `in_size`, zero-extended.
- R8: `done` is a single-cycle pulse that rises on the 45th rising edge after the edge that accepted `start`. `busy` is high from the accepting edge until `done` rises, and low while `done` is high.
- R9: A `start` seen while `busy` is high is ignored. It changes neither the pending result nor the number of `done` pulses.
- R10: After reset, `busy`, `done`, `step`, `phase` and `bpp_warn` are all 0. The result outputs change only on the edge where `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request a calculation; taken only when `busy` is low |
| in_size | input | 32 | Source size, unsigned 20.12 |
| out_size | input | 32 | Destination size, unsigned 20.12 |
| vert | input | 1 | 1 selects the vertical axis, 0 the horizontal axis |
| bpp | input | 3 | Bytes per pixel for the horizontal ceiling |
| busy | output | 1 | A calculation is in progress |
| done | output | 1 | One-cycle pulse when the result updates |
| step | output | 32 | Clamped step, unsigned 20.12 |
| phase | output | 32 | Initial phase, unsigned 20.12 |
| bpp_warn | output | 1 | An unsupported byte count fell back to the 4-byte ceiling |

## Verification
The bound checker watches, on every cycle, the pulse shape and the exact latency of `done`, the busy window, the absence of any `done` without an accepted request, and that the result outputs change only with `done`. At each `done` it also checks the ceiling rules, the warning flag, the phase field and the zero step for sub-unit sources. The exact quotient values, the divisor floor, and the evidence that a request raised during a calculation leaves the result untouched can only be shown by the bench. The bench does this by comparing each result with an independently computed model across up-scaling, down-scaling, clamping and degenerate sizes.

// File: rtl/scl_dda_pkg.sv
package scl_dda_pkg;

  // Integer parts of the step ceilings
  localparam int unsigned CEIL_VERT_INT   = 15;
  localparam int unsigned CEIL_WIDE_INT   = 8;
  localparam int unsigned CEIL_NARROW_INT = 4;

  // Byte-per-pixel codes with a dedicated horizontal ceiling
  localparam int unsigned BPP_CODE_TWO  = 2;
  localparam int unsigned BPP_CODE_FOUR = 4;

  typedef enum logic [1:0] {
    CEIL_VERT     = 2'd0,
    CEIL_WIDE     = 2'd1,
    CEIL_NARROW   = 2'd2,
    CEIL_FALLBACK = 2'd3
  } ceil_kind_e;

endpackage

// File: rtl/scl_operand_prep.sv
module scl_operand_prep #(
  parameter int unsigned FX_W   = 32,
  parameter int unsigned FRAC_W = 12
) (
  input  logic [FX_W-1:0]  in_fx,
  input  logic [FX_W-1:0]  out_fx,
  output logic [FX_W-1:0]  dividend_o,
  output logic [FX_W-1:0]  divisor_o,
  output logic [FX_W-1:0]  phase_o
);

  localparam logic [FX_W-1:0] UNIT_FX = FX_W'(1) << FRAC_W;
  localparam logic [FX_W-1:0] PAIR_FX = FX_W'(2) << FRAC_W;

  always_comb begin
    // Source span: size less one unit, never negative
    if (in_fx >= UNIT_FX) begin
      dividend_o = in_fx - UNIT_FX;
    end else begin
      dividend_o = '0;
    end

    // Destination span: size less one unit, floored at one unit
    if (out_fx >= PAIR_FX) begin
      divisor_o = out_fx - UNIT_FX;
    end else begin
      divisor_o = UNIT_FX;
    end

    phase_o = FX_W'(in_fx[FRAC_W-1:0]);
  end

endmodule

// File: rtl/scl_limit_sel.sv
module scl_limit_sel
  import scl_dda_pkg::*;
#(
  parameter int unsigned FX_W   = 32,
  parameter int unsigned FRAC_W = 12,
  parameter int unsigned BPP_W  = 3
) (
  input  logic             vert_i,
  input  logic [BPP_W-1:0] bpp_i,
  output logic [FX_W-1:0]  ceil_o,
  output logic             warn_o
);

  localparam logic [FX_W-1:0] CEIL_V_FX = FX_W'(CEIL_VERT_INT)   << FRAC_W;
  localparam logic [FX_W-1:0] CEIL_W_FX = FX_W'(CEIL_WIDE_INT)   << FRAC_W;
  localparam logic [FX_W-1:0] CEIL_N_FX = FX_W'(CEIL_NARROW_INT) << FRAC_W;

  ceil_kind_e kind;

  always_comb begin
    if (vert_i) begin
      kind = CEIL_VERT;
    end else if (bpp_i == BPP_W'(BPP_CODE_TWO)) begin
      kind = CEIL_WIDE;
    end else if (bpp_i == BPP_W'(BPP_CODE_FOUR)) begin
      kind = CEIL_NARROW;
    end else begin
      kind = CEIL_FALLBACK;
    end
  end

  always_comb begin
    warn_o = 1'b0;
    unique case (kind)
      CEIL_VERT:     ceil_o = CEIL_V_FX;
      CEIL_WIDE:     ceil_o = CEIL_W_FX;
      CEIL_NARROW:   ceil_o = CEIL_N_FX;
      CEIL_FALLBACK: begin
        ceil_o = CEIL_N_FX;
        warn_o = 1'b1;
      end
      default:       ceil_o = CEIL_N_FX;
    endcase
  end

endmodule

// File: rtl/scl_restoring_div.sv
module scl_restoring_div #(
  parameter int unsigned NUM_W = 44,
  parameter int unsigned DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [NUM_W-1:0] quo_o
);

  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, rem_d;
  logic [NUM_W-1:0] acc_q, acc_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fin_q, fin_d;

  logic [DEN_W:0]   rem_sh;
  logic             take;
  logic [DEN_W-1:0] diff;

  // One trial subtraction per clock, dividend bits enter from the top
  always_comb begin
    rem_sh = {rem_q, acc_q[NUM_W-1]};
    take   = rem_sh >= {1'b0, den_q};
    diff   = rem_sh[DEN_W-1:0] - den_q;

    rem_d = rem_q;
    acc_d = acc_q;
    den_d = den_q;
    cnt_d = cnt_q;
    fin_d = 1'b0;

    if (load_i) begin
      rem_d = '0;
      acc_d = num_i;
      den_d = den_i;
      cnt_d = CNT_W'(NUM_W);
    end else if (cnt_q != '0) begin
      rem_d = take ? diff : rem_sh[DEN_W-1:0];
      acc_d = {acc_q[NUM_W-2:0], take};
      cnt_d = cnt_q - CNT_W'(1);
      fin_d = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      acc_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      acc_q <= acc_d;
      den_q <= den_d;
      cnt_q <= cnt_d;
      fin_q <= fin_d;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign fin_o  = fin_q;
  assign quo_o  = acc_q;

endmodule

// File: rtl/scl_dda_step.sv
module scl_dda_step #(
  parameter int unsigned INT_W  = 20,
  parameter int unsigned FRAC_W = 12,
  parameter int unsigned BPP_W  = 3,
  localparam int unsigned FX_W  = INT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FX_W-1:0]  in_size,
  input  logic [FX_W-1:0]  out_size,
  input  logic             vert,
  input  logic [BPP_W-1:0] bpp,
  output logic             busy,
  output logic             done,
  output logic [FX_W-1:0]  step,
  output logic [FX_W-1:0]  phase,
  output logic             bpp_warn
);

  localparam int unsigned NUM_W = FX_W + FRAC_W;

  logic [FX_W-1:0]  dividend, divisor, phase_in;
  logic             div_busy, div_fin;
  logic [NUM_W-1:0] quotient;
  logic             accept;

  // Request configuration held for the result stage
  logic             cfg_vert_q, cfg_vert_d;
  logic [BPP_W-1:0] cfg_bpp_q, cfg_bpp_d;
  logic [FX_W-1:0]  cfg_phase_q, cfg_phase_d;

  logic [FX_W-1:0]  ceil_fx;
  logic             ceil_warn;
  logic [FX_W-1:0]  clamped;

  logic [FX_W-1:0]  step_q, step_d;
  logic [FX_W-1:0]  phase_q, phase_d;
  logic             warn_q, warn_d;
  logic             done_q, done_d;

  assign busy   = div_busy | div_fin;
  assign accept = start & ~busy;

  scl_operand_prep #(
    .FX_W   (FX_W),
    .FRAC_W (FRAC_W)
  ) i_prep (
    .in_fx      (in_size),
    .out_fx     (out_size),
    .dividend_o (dividend),
    .divisor_o  (divisor),
    .phase_o    (phase_in)
  );

  scl_restoring_div #(
    .NUM_W (NUM_W),
    .DEN_W (FX_W)
  ) i_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .num_i  ({dividend, {FRAC_W{1'b0}}}),
    .den_i  (divisor),
    .busy_o (div_busy),
    .fin_o  (div_fin),
    .quo_o  (quotient)
  );

  scl_limit_sel #(
    .FX_W   (FX_W),
    .FRAC_W (FRAC_W),
    .BPP_W  (BPP_W)
  ) i_lim (
    .vert_i (cfg_vert_q),
    .bpp_i  (cfg_bpp_q),
    .ceil_o (ceil_fx),
    .warn_o (ceil_warn)
  );

  // Next state: configuration capture on accept, result capture on finish
  always_comb begin
    cfg_vert_d  = cfg_vert_q;
    cfg_bpp_d   = cfg_bpp_q;
    cfg_phase_d = cfg_phase_q;
    if (accept) begin
      cfg_vert_d  = vert;
      cfg_bpp_d   = bpp;
      cfg_phase_d = phase_in;
    end

    if (quotient > NUM_W'(ceil_fx)) begin
      clamped = ceil_fx;
    end else begin
      clamped = quotient[FX_W-1:0];
    end

    step_d  = step_q;
    phase_d = phase_q;
    warn_d  = warn_q;
    done_d  = 1'b0;
    if (div_fin) begin
      step_d  = clamped;
      phase_d = cfg_phase_q;
      warn_d  = ceil_warn;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_vert_q  <= 1'b0;
      cfg_bpp_q   <= '0;
      cfg_phase_q <= '0;
      step_q      <= '0;
      phase_q     <= '0;
      warn_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      cfg_vert_q  <= cfg_vert_d;
      cfg_bpp_q   <= cfg_bpp_d;
      cfg_phase_q <= cfg_phase_d;
      step_q      <= step_d;
      phase_q     <= phase_d;
      warn_q      <= warn_d;
      done_q      <= done_d;
    end
  end

  assign done     = done_q;
  assign step     = step_q;
  assign phase    = phase_q;
  assign bpp_warn = warn_q;

endmodule

// File: rtl/scl_dda_step_chk.sv
module scl_dda_step_chk #(
  parameter int unsigned INT_W  = 20,
  parameter int unsigned FRAC_W = 12,
  parameter int unsigned BPP_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [INT_W+FRAC_W-1:0] in_size,
  input logic                    vert,
  input logic [BPP_W-1:0]        bpp,
  input logic                    busy,
  input logic                    done,
  input logic [INT_W+FRAC_W-1:0] step,
  input logic [INT_W+FRAC_W-1:0] phase,
  input logic                    bpp_warn
);

  localparam int unsigned FX_W = INT_W + FRAC_W;
  localparam int unsigned LAT  = FX_W + FRAC_W + 1;
  localparam int unsigned CW   = $clog2(LAT + 2);
  localparam logic [FX_W-1:0] UNIT = FX_W'(1)  << FRAC_W;
  localparam logic [FX_W-1:0] LV   = FX_W'(15) << FRAC_W;
  localparam logic [FX_W-1:0] LW   = FX_W'(8)  << FRAC_W;
  localparam logic [FX_W-1:0] LN   = FX_W'(4)  << FRAC_W;

  logic             acc;
  logic             trk;
  logic [CW-1:0]    cnt;
  logic             l_vert;
  logic [BPP_W-1:0] l_bpp;
  logic [FX_W-1:0]  l_in;
  logic             l_odd;

  assign acc   = start & ~busy;
  assign l_odd = (l_bpp != BPP_W'(2)) && (l_bpp != BPP_W'(4));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk    <= 1'b0;
      cnt    <= '0;
      l_vert <= 1'b0;
      l_bpp  <= '0;
      l_in   <= '0;
    end else begin
      if (acc) begin
        trk    <= 1'b1;
        cnt    <= '0;
        l_vert <= vert;
        l_bpp  <= bpp;
        l_in   <= in_size;
      end else begin
        if (done) trk <= 1'b0;
        if (trk && cnt != CW'(LAT + 1)) cnt <= cnt + CW'(1);
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == CW'(LAT)));
  assert_busy_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trk && !done) |-> busy);
  assert_idle_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_no_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> trk);
  assert_sub_unit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && l_in < UNIT) |-> (step == '0));
  assert_vert_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && l_vert) |-> (step <= LV));
  assert_wide_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !l_vert && l_bpp == BPP_W'(2)) |-> (step <= LW));
  assert_narrow_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !l_vert && l_bpp != BPP_W'(2)) |-> (step <= LN));
  assert_warn_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bpp_warn == (!l_vert && l_odd)));
  assert_phase_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == FX_W'(l_in[FRAC_W-1:0])));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({step, phase, bpp_warn}) |-> done);

endmodule

bind scl_dda_step scl_dda_step_chk #(
  .INT_W  (INT_W),
  .FRAC_W (FRAC_W),
  .BPP_W  (BPP_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .in_size  (in_size),
  .vert     (vert),
  .bpp      (bpp),
  .busy     (busy),
  .done     (done),
  .step     (step),
  .phase    (phase),
  .bpp_warn (bpp_warn)
);

// File: tb/test_scl_dda_step.sv
module test_scl_dda_step;

  localparam int unsigned LAT_EDGES = 45;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] in_size;
  logic [31:0] out_size;
  logic        vert;
  logic [2:0]  bpp;
  logic        busy;
  logic        done;
  logic [31:0] step;
  logic [31:0] phase;
  logic        bpp_warn;

  int unsigned checks;
  int unsigned errors;
  int unsigned cyc;

  typedef struct {
    logic [31:0] step;
    logic [31:0] phase;
    logic        warn;
    int unsigned cyc;
    string       req;
  } exp_t;

  exp_t sb[$];

  scl_dda_step i_scl_dda_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_size  (in_size),
    .out_size (out_size),
    .vert     (vert),
    .bpp      (bpp),
    .busy     (busy),
    .done     (done),
    .step     (step),
    .phase    (phase),
    .bpp_warn (bpp_warn)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements (R1..R7)
  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                 input logic v, input logic [2:0] p);
    exp_t e;
    longint unsigned dvd, dvs, q, lim;
    dvd = (a >= 32'h1000) ? longint'(a) - 64'h1000 : 64'd0;
    dvs = (b >= 32'h2000) ? longint'(b) - 64'h1000 : 64'h1000;
    q   = (dvd << 12) / dvs;
    if (v)            lim = 64'hF000;
    else if (p == 2)  lim = 64'h8000;
    else              lim = 64'h4000;
    e.step  = (q > lim) ? lim[31:0] : q[31:0];
    e.phase = {20'd0, a[11:0]};
    e.warn  = !v && (p != 3'd2) && (p != 3'd4);
    return e;
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic v, input logic [2:0] p, input string req);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e     = model(a, b, v, p);
    e.cyc = cyc;
    e.req = req;
    sb.push_back(e);
    in_size  = a;
    out_size = b;
    vert     = v;
    bpp      = p;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic drain;
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "done without request", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(step == e.step, e.req, "step", step, e.step);
        check(phase == e.phase, "R7", "phase", phase, e.phase);
        check(bpp_warn == e.warn, "R6", "bpp_warn", {31'd0, bpp_warn}, {31'd0, e.warn});
        check((cyc - e.cyc) == LAT_EDGES + 1, "R8", "latency",
              cyc - e.cyc, LAT_EDGES + 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    checks   = 0;
    errors   = 0;
    cyc      = 0;
    rst_n    = 1'b0;
    start    = 1'b0;
    in_size  = '0;
    out_size = '0;
    vert     = 1'b0;
    bpp      = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check({busy, done, bpp_warn} == 3'b000, "R10", "reset flags",
          {29'd0, busy, done, bpp_warn}, 32'd0);
    check(step == 0 && phase == 0, "R10", "reset result", step | phase, 32'd0);

    issue(32'd1920 << 12, 32'd1280 << 12, 1'b0, 3'd4, "R3");
    issue(32'd640  << 12, 32'd1920 << 12, 1'b1, 3'd4, "R3");
    issue(32'd4096 << 12, 32'd256  << 12, 1'b0, 3'd2, "R5");
    issue(32'd4096 << 12, 32'd512  << 12, 1'b0, 3'd4, "R5");
    issue(32'd4096 << 12, 32'd100  << 12, 1'b1, 3'd2, "R4");
    issue(32'd800  << 12, 32'd600  << 12, 1'b0, 3'd3, "R6");
    issue(32'd4096 << 12, 32'd256  << 12, 1'b1, 3'd0, "R6");
    issue(32'd3    << 12, 32'd1    << 12, 1'b1, 3'd4, "R2");
    issue(32'd10   << 12, 32'd0,          1'b1, 3'd4, "R2");
    issue(32'd0,          32'd50   << 12, 1'b0, 3'd4, "R1");
    issue(32'h0000_0800,  32'd50   << 12, 1'b1, 3'd4, "R1");
    issue((32'd100 << 12) | 32'hC00, 32'd50 << 12, 1'b0, 3'd2, "R7");
    drain();

    // R9: a second request during a calculation is ignored
    issue(32'd1000 << 12, 32'd300 << 12, 1'b1, 3'd4, "R9");
    @(negedge clk);
    check(busy == 1'b1, "R9", "busy during run", {31'd0, busy}, 32'd1);
    in_size  = 32'd7 << 12;
    out_size = 32'd7 << 12;
    vert     = 1'b0;
    bpp      = 3'd5;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    drain();
    held = step;
    repeat (80) @(negedge clk);
    // R10: outputs hold with no further done; R9: no extra pulse seen by monitor
    check(step == held, "R10", "step hold", step, held);
    check(busy == 1'b0, "R9", "idle after ignored start", {31'd0, busy}, 32'd0);

    // R8: back-to-back requests
    issue(32'd17 << 12, 32'd5 << 12, 1'b0, 3'd2, "R8");
    issue(32'd5  << 12, 32'd17 << 12, 1'b0, 3'd2, "R8");
    drain();
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule